// File: doc/BRIEF.md
# Transparent Receiver Sync Front End

This block sits at the input of a fully transparent serial receiver. It receives one line sample per bit strobe and decodes it as plain NRZ or as NRZI. It then decides where octet alignment begins and packs the aligned bits into octets. Alignment can come from one of four sources:

- a falling edge on the active-low carrier-detect input;
- a permanent "always aligned" setting;
- a hunt for the lower half of a programmable sync word;
- a hunt for the full sync word.

Each completed octet appears on a one-clock valid strobe. The caller selects the order in which bits are packed into the octet. In the two hunt modes, carrier detect is treated as a level. If the carrier goes away while aligned, the block raises a one-clock loss error, drops alignment and goes back to hunting.

Top module: `tsync_rx`

## Requirements
- R1: When `dec_mode` is 2'b00 the decoded bit equals the line sample. When `dec_mode` is 2'b01 (NRZI) the decoded bit is 1 if the sample equals the previous strobed sample, and 0 if it differs. The previous sample is taken as 1 after reset.
- R2: The reserved `dec_mode` values 2'b10 and 2'b11 decode exactly like 2'b00.
- R3: With `sync_mode` 2'b00, alignment starts on the strobe where `cd_n` is sampled low after having been sampled high. The previous sample is taken as high after reset. The bit on that strobe is the first data bit. Alignment holds while `cd_n` stays low. A strobe with `cd_n` high ends alignment without raising `cd_lost`.
- R4: With `sync_mode` 2'b01, `in_sync` is always 1 and `cd_n` has no effect. Octet packing starts with the first strobe after reset.
- R5: With `sync_mode` 2'b10, the block hunts for the decoded sequence `sync_pat[7]` down to `sync_pat[0]`, sent in that order, while `cd_n` is low. The bit after the last pattern bit is the first data bit.
- R6: With `sync_mode` 2'b11, the hunt needs all 16 bits, sent in order from `sync_pat[15]` down to `sync_pat[0]`. A match on the low 8 bits alone does not align the block.
- R7: In the hunt modes, an aligned strobe with `cd_n` high does three things: it pulses `cd_lost` for exactly one clock, it clears `in_sync`, and it restarts the hunt. A later pattern then realigns the block.
- R8: With `rev_data` 0, the first bit of an octet lands in `oct_data[0]`. With `rev_data` 1, it lands in `oct_data[7]`.
- R9: `oct_valid` goes high for one clock, on the clock after the strobe that carried the eighth bit. `oct_data` holds the octet until the next one arrives.
- R10: After reset, `oct_valid` and `cd_lost` are 0, and `in_sync` is 0 unless `sync_mode` is 2'b01.
- R11: A hunt cannot match until the full pattern length of bits has been shifted in since reset or since the last loss. Stale register contents never produce alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-clock strobe marking a valid line sample |
| line_in | input | 1 | Serial line sample |
| cd_n | input | 1 | Active-low carrier detect |
| sync_mode | input | 2 | Alignment source select |
| dec_mode | input | 2 | Line decode select |
| rev_data | input | 1 | Pack first bit into MSB when 1 |
| sync_pat | input | SYNC_W | Sync word to hunt for |
| oct_data | output | OCT_W | Last completed octet |
| oct_valid | output | 1 | One-clock strobe for a new octet |
| cd_lost | output | 1 | One-clock carrier-loss error |
| in_sync | output | 1 | Alignment status |

## Verification
The bench builds the block with its default parameters: a 16-bit sync word and 8-bit octets. These defaults make both hunt lengths reachable in one build. They also make it possible to check that an 8-bit partial match is rejected in the 16-bit mode. Random octets, decode modes, bit orders and strobe gaps cover the packing path. Directed runs cover carrier-edge start, carrier loss followed by realignment, and a carrier that is absent during a hunt.

// File: rtl/tsync_rx.sv
module tsync_rx #(
  parameter int SYNC_W = 16,
  parameter int OCT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              line_in,
  input  logic              cd_n,
  input  logic [1:0]        sync_mode,
  input  logic [1:0]        dec_mode,
  input  logic              rev_data,
  input  logic [SYNC_W-1:0] sync_pat,
  output logic [OCT_W-1:0]  oct_data,
  output logic              oct_valid,
  output logic              cd_lost,
  output logic              in_sync
);
  localparam int HALF = SYNC_W / 2;
  localparam int CW   = $clog2(OCT_W);
  localparam int FW   = $clog2(SYNC_W + 1);
  localparam logic [FW-1:0] FILL_MAX  = FW'(SYNC_W);
  localparam logic [FW-1:0] NEED_LONG = FW'(SYNC_W - 1);
  localparam logic [FW-1:0] NEED_HALF = FW'(HALF - 1);
  localparam logic [CW-1:0] LAST_BIT  = CW'(OCT_W - 1);

  logic              prev_line, cd_q, sync_q;
  logic [SYNC_W-1:0] hunt_sr;
  logic [FW-1:0]     fill;
  logic [CW-1:0]     bcnt;
  logic [OCT_W-1:0]  acc;

  wire bit_d    = (dec_mode == 2'b01) ? (line_in ~^ prev_line) : line_in;
  wire mode_ext = (sync_mode == 2'b00);
  wire mode_auto = (sync_mode == 2'b01);
  wire mode_pat = sync_mode[1];

  wire [SYNC_W-1:0] sr_nx = {hunt_sr[SYNC_W-2:0], bit_d};
  wire filled = fill >= (sync_mode[0] ? NEED_LONG : NEED_HALF);
  wire pat_eq = sync_mode[0] ? (sr_nx == sync_pat)
                             : (sr_nx[HALF-1:0] == sync_pat[HALF-1:0]);
  wire match  = mode_pat & ~cd_n & filled & pat_eq;
  wire fall   = cd_q & ~cd_n;
  wire take   = mode_auto | (~cd_n & (sync_q | (mode_ext & fall)));

  wire [OCT_W-1:0] acc_nx = rev_data ? {acc[OCT_W-2:0], bit_d}
                                     : {bit_d, acc[OCT_W-1:1]};
  wire last = (bcnt == LAST_BIT);

  assign in_sync = mode_auto | sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_line <= 1'b1;
      cd_q      <= 1'b1;
      sync_q    <= 1'b0;
      hunt_sr   <= '0;
      fill      <= '0;
      bcnt      <= '0;
      acc       <= '0;
      oct_data  <= '0;
      oct_valid <= 1'b0;
      cd_lost   <= 1'b0;
    end else begin
      oct_valid <= 1'b0;
      cd_lost   <= 1'b0;
      if (bit_en) begin
        prev_line <= line_in;
        cd_q      <= cd_n;
        hunt_sr   <= sr_nx;
        if (mode_pat) begin
          if (sync_q) begin
            if (cd_n) begin
              cd_lost <= 1'b1;
              sync_q  <= 1'b0;
              fill    <= '0;
            end
          end else begin
            sync_q <= match;
            if (fill != FILL_MAX) fill <= fill + 1'b1;
          end
        end else begin
          sync_q <= mode_ext & take;
        end
        if (take) begin
          acc  <= acc_nx;
          bcnt <= last ? '0 : bcnt + 1'b1;
          if (last) begin
            oct_data  <= acc_nx;
            oct_valid <= 1'b1;
          end
        end else begin
          bcnt <= '0;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    oct_valid |=> !oct_valid); // R9
  AST_LOST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cd_lost |=> !cd_lost); // R7
  AST_LOST_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_lost && sync_mode[1]) |-> !in_sync); // R7
  AST_LOST_ONLY_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cd_lost |-> $past(sync_mode[1])); // R3
  AST_VALID_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    oct_valid |-> $past(in_sync)); // R9
endmodule

// File: tb/tsync_rx_tb.sv
module tsync_rx_tb;
  logic clk = 0, rst_n = 0, bit_en = 0, line_in = 1, cd_n = 1, rev_data = 0;
  logic [1:0] sync_mode = 2'b01, dec_mode = 2'b00;
  logic [15:0] sync_pat = 16'hD3A5;
  logic [7:0] oct_data;
  logic oct_valid, cd_lost, in_sync;

  int checks = 0, fails = 0, rx_n = 0, lost_n = 0, gap = 0;
  logic tline = 1;
  logic [7:0] rx_q [0:255];
  logic [7:0] exp_q [0:15];

  always #2 clk = ~clk;

  tsync_rx u_dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_in(line_in),
    .cd_n(cd_n), .sync_mode(sync_mode), .dec_mode(dec_mode), .rev_data(rev_data),
    .sync_pat(sync_pat), .oct_data(oct_data), .oct_valid(oct_valid),
    .cd_lost(cd_lost), .in_sync(in_sync));

  always @(negedge clk) if (rst_n) begin
    if (oct_valid) begin rx_q[rx_n[7:0]] = oct_data; rx_n++; end
    if (cd_lost) lost_n++;
  end

  function automatic logic enc(input logic b, input logic prev, input logic [1:0] dm);
    return (dm == 2'b01) ? (b ? prev : ~prev) : b;
  endfunction

  function automatic logic oct_bit(input logic [7:0] o, input int i, input logic rv);
    return rv ? o[7-i] : o[i];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic do_reset(input logic [1:0] sm, input logic [1:0] dm, input logic rv);
    @(negedge clk);
    rst_n = 0; sync_mode = sm; dec_mode = dm; rev_data = rv; bit_en = 0;
    tline = 1; line_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    tline = enc(b, tline, dec_mode);
    line_in = tline; bit_en = 1;
    @(negedge clk);
    bit_en = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_oct(input logic [7:0] o);
    for (int i = 0; i < 8; i++) send_bit(oct_bit(o, i, rev_data));
  endtask

  task automatic send_pat(input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(sync_pat[i]);
  endtask

  task automatic cmp_octs(input int base, input int n, input string tag);
    repeat (2) @(negedge clk);
    chk(rx_n - base == n, {tag, " count"}, rx_n - base, n);
    for (int k = 0; k < n; k++)
      chk(rx_q[(base + k) % 256] == exp_q[k], tag, rx_q[(base + k) % 256], exp_q[k]);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base, lb;
    void'($urandom(32'd1234));

    // R10 reset state in a hunt mode
    do_reset(2'b10, 2'b00, 0);
    chk(!oct_valid && !cd_lost && !in_sync, "R10 reset outputs", {oct_valid, cd_lost, in_sync}, 0);
    do_reset(2'b01, 2'b00, 0);
    chk(in_sync, "R10 auto mode in_sync", in_sync, 1);

    // R4 R1 R8 auto mode NRZ, cd_n toggled
    base = rx_n;
    for (int k = 0; k < 4; k++) begin
      exp_q[k] = 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        cd_n = 1'($urandom);
        send_bit(oct_bit(exp_q[k], i, 0));
      end
    end
    cmp_octs(base, 4, "R4 R1 R8 auto NRZ");
    chk(in_sync && lost_n == 0, "R4 cd ignored", lost_n, 0);

    // R9 valid pulse width and hold
    exp_q[0] = 8'h5A;
    for (int i = 0; i < 7; i++) send_bit(oct_bit(exp_q[0], i, 0));
    tline = enc(exp_q[0][7], tline, dec_mode);
    line_in = tline; bit_en = 1;
    @(negedge clk); bit_en = 0;
    chk(oct_valid && oct_data == 8'h5A, "R9 valid after eighth strobe", oct_data, 8'h5A);
    @(negedge clk);
    chk(!oct_valid && oct_data == 8'h5A, "R9 one clock and hold", {oct_valid, oct_data}, 8'h5A);

    // R1 R8 NRZI reversed
    do_reset(2'b01, 2'b01, 1);
    base = rx_n;
    for (int k = 0; k < 3; k++) begin exp_q[k] = 8'($urandom); send_oct(exp_q[k]); end
    cmp_octs(base, 3, "R1 R8 NRZI reversed");

    // R2 reserved decode acts as NRZ
    do_reset(2'b01, 2'b10, 0);
    base = rx_n;
    for (int k = 0; k < 2; k++) begin exp_q[k] = 8'($urandom); send_oct(exp_q[k]); end
    cmp_octs(base, 2, "R2 reserved decode");

    // R3 external carrier edge start
    cd_n = 1;
    do_reset(2'b00, 2'b00, 0);
    for (int i = 0; i < 5; i++) send_bit(1'($urandom));
    chk(!in_sync, "R3 no sync before edge", in_sync, 0);
    base = rx_n; lb = lost_n;
    cd_n = 0;
    for (int k = 0; k < 3; k++) begin exp_q[k] = 8'($urandom); send_oct(exp_q[k]); end
    cmp_octs(base, 3, "R3 edge start");
    cd_n = 1; send_bit(0); @(negedge clk);
    chk(!in_sync && lost_n == lb, "R3 drop without error", {in_sync, 8'(lost_n - lb)}, 0);

    // R5 8-bit hunt, R7 loss and resync
    cd_n = 0;
    sync_pat = 16'h3CA5;
    do_reset(2'b10, 2'b00, 0);
    for (int i = 0; i < 4; i++) send_bit(0);
    send_pat(8);
    chk(in_sync, "R5 sync after 8-bit pattern", in_sync, 1);
    base = rx_n;
    for (int k = 0; k < 2; k++) begin exp_q[k] = 8'($urandom); send_oct(exp_q[k]); end
    cmp_octs(base, 2, "R5 data after pattern");
    lb = lost_n;
    cd_n = 1; send_bit(0); @(negedge clk);
    chk(lost_n - lb == 1, "R7 single loss pulse", lost_n - lb, 1);
    chk(!in_sync, "R7 sync dropped", in_sync, 1'b0);
    cd_n = 0; send_pat(8);
    base = rx_n;
    exp_q[0] = 8'h96; send_oct(exp_q[0]);
    cmp_octs(base, 1, "R7 resync after loss");

    // R5 no sync when carrier absent during hunt
    cd_n = 1;
    do_reset(2'b10, 2'b00, 0);
    for (int i = 0; i < 4; i++) send_bit(0);
    send_pat(8);
    chk(!in_sync, "R5 carrier required", in_sync, 0);

    // R11 zero pattern not matched by reset contents
    cd_n = 0; sync_pat = 16'h0000;
    do_reset(2'b11, 2'b00, 0);
    for (int i = 0; i < 3; i++) send_bit(0);
    chk(!in_sync, "R11 fill required", in_sync, 0);

    // R6 partial match rejected, full match accepted, NRZI
    sync_pat = 16'hD3A5;
    do_reset(2'b11, 2'b01, 0);
    for (int i = 0; i < 10; i++) send_bit(0);
    send_pat(8);
    chk(!in_sync, "R6 half pattern rejected", in_sync, 0);
    send_pat(16);
    chk(in_sync, "R6 full pattern", in_sync, 1);
    base = rx_n;
    for (int k = 0; k < 2; k++) begin exp_q[k] = 8'($urandom); send_oct(exp_q[k]); end
    cmp_octs(base, 2, "R6 data after pattern");

    // random auto-mode runs
    for (int it = 0; it < 6; it++) begin
      logic [1:0] dm;
      logic rv;
      dm = 2'($urandom); rv = 1'($urandom);
      do_reset(2'b01, dm, rv);
      gap = $urandom_range(0, 2);
      base = rx_n;
      for (int k = 0; k < 3; k++) begin exp_q[k] = 8'($urandom); send_oct(exp_q[k]); end
      cmp_octs(base, 3, "R1 R2 R8 random");
    end
    gap = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule